// File: doc/BRIEF.md
# Stack and Control-Flow Sequencer for an 8-bit Core

This block carries out every operation of an 8-bit accumulator core that goes through the hardware stack. It saves and restores the accumulator and the processor status. It performs subroutine call and return, the software break trap, and return from interrupt. It owns the 8-bit stack pointer, which addresses a fixed 256-byte stack page. It also owns the conversion between the six individual flags and the status byte kept on the stack.

The surrounding core decodes an instruction and pulses `start` with an operation code. With it the core presents the instruction's address, the call target, the accumulator and the flags. The sequencer then makes one byte transfer per clock on a single read/write memory port, with read data returned combinationally in the same cycle. One cycle after its last transfer it raises `done` for a single cycle. In that cycle it also strobes whichever results the operation produces: a new program counter, a new accumulator, or a new set of flags.

Top module: `stackseq`

## Requirements
- R1: A push writes its byte to address {0x01, SP} and then decrements SP by one, wrapping modulo 256.
- R2: A pull first increments SP by one, wrapping modulo 256, and reads the byte at {0x01, SP} using the incremented value.
- R3: A pushed status byte carries C at bit 0, Z at bit 1, I at bit 2, D at bit 3, V at bit 6 and N at bit 7, with bits 4 and 5 always 1. The flag buses are ordered {N,V,D,I,Z,C}, from bit 5 down to bit 0.
- R4: Pulling the status (op 3) loads all six flags from their bit positions in the pulled byte and ignores bits 4 and 5. `flags_load` pulses with `done`.
- R5: Pulling the accumulator (op 2) outputs the pulled byte on `a_out` with `a_load`. It sets Z when the byte is zero and N to the byte's bit 7, keeps V, D, I and C, and pulses `flags_load`.
- R6: Pushing the accumulator (op 0) or the status (op 1) writes one byte and raises none of `pc_load`, `a_load` or `flags_load`.
- R7: A call (op 4) computes R = instruction address + 2, modulo 2^16. It pushes the high byte of R and then the low byte, then loads the call target into the PC.
- R8: A return (op 5) pulls the low byte and then the high byte, and loads that 16-bit address + 1, modulo 2^16, into the PC.
- R9: A break (op 6) pushes the high and low bytes of its address + 2, then the status byte. It then reads 0xFFFE (PC low) and 0xFFFF (PC high), loads that PC, and outputs the flags with D cleared and I set.
- R10: A return from interrupt (op 7) pulls status, then PC low, then PC high. It loads the flags as in R4 and the PC with no increment.
- R11: Each memory transfer takes exactly one clock. `busy` is high from the clock after `start` until the clock that raises `done`. `done` is a one-cycle pulse one clock after the last transfer. A `start` seen while busy is ignored.
- R12: After reset SP is 0xFD, the sequencer is idle, and no memory access or strobe is active.
- R13: The operation codes are 0 push A, 1 push status, 2 pull A, 3 pull status, 4 call, 5 return, 6 break and 7 return from interrupt. They take 1, 1, 1, 1, 2, 2, 5 and 3 transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the operation given on `op` (taken only when idle) |
| op | input | 3 | Operation code (see R13) |
| pc_in | input | 16 | Address of the instruction being executed |
| target | input | 16 | Subroutine call target |
| a_in | input | 8 | Current accumulator |
| flags_in | input | 6 | Current flags {N,V,D,I,Z,C} |
| mem_addr | output | 16 | Memory port address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the cycle of `mem_re` |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load strobe for `pc_out` |
| a_out | output | 8 | New accumulator |
| a_load | output | 1 | Load strobe for `a_out` |
| flags_out | output | 6 | New flags {N,V,D,I,Z,C} |
| flags_load | output | 1 | Load strobe for `flags_out` |
| sp_out | output | 8 | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
The bench uses return addresses whose low byte is 0xFF. A design that added the offset to the low byte alone would return to the wrong page. It checks that the +1 applies to a subroutine return and not to an interrupt return, which catches a design that shares one path for both. Pulled status bytes have bits 4 and 5 cleared and also set, so a design that leaked those bits into V or D would be caught. The bench also checks the exact order of the stacked return address and status against the address log, and pulses `start` in the middle of a call, where a design that re-triggered would move SP twice.

// File: rtl/stackseq_pkg.sv
`timescale 1ns/1ps
package stackseq_pkg;
  localparam int DATA_W = 8;
  localparam int PC_W   = 16;
  localparam int FLAG_W = 6;
  localparam int STEP_W = 3;
  // flag positions inside the {N,V,D,I,Z,C} bus
  localparam int F_N = 5;
  localparam int F_V = 4;
  localparam int F_D = 3;
  localparam int F_I = 2;
  localparam int F_Z = 1;
  localparam int F_C = 0;

  typedef enum logic [2:0] {
    OP_PUSH_A = 3'd0, OP_PUSH_P = 3'd1, OP_PULL_A = 3'd2, OP_PULL_P = 3'd3,
    OP_CALL   = 3'd4, OP_RET    = 3'd5, OP_BREAK  = 3'd6, OP_IRET   = 3'd7
  } sop_e;

  typedef enum logic [1:0] {ACC_NONE, ACC_PUSH, ACC_PULL, ACC_VEC} acc_e;
  typedef enum logic [1:0] {WD_ACC, WD_STAT, WD_RETH, WD_RETL} wsel_e;

  function automatic logic [DATA_W-1:0] pack_status(input logic [FLAG_W-1:0] f);
    return {f[F_N], f[F_V], 2'b11, f[F_D], f[F_I], f[F_Z], f[F_C]};
  endfunction

  function automatic logic [FLAG_W-1:0] unpack_status(input logic [DATA_W-1:0] b);
    logic [FLAG_W-1:0] r;
    r[F_N] = b[7];
    r[F_V] = b[6];
    r[F_D] = b[3];
    r[F_I] = b[2];
    r[F_Z] = b[1];
    r[F_C] = b[0];
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] nz_update(input logic [FLAG_W-1:0] f,
                                                  input logic [DATA_W-1:0] v);
    logic [FLAG_W-1:0] r;
    r = f;
    r[F_N] = v[DATA_W-1];
    r[F_Z] = (v == '0);
    return r;
  endfunction

  function automatic logic [FLAG_W-1:0] trap_flags(input logic [FLAG_W-1:0] f);
    logic [FLAG_W-1:0] r;
    r = f;
    r[F_D] = 1'b0;
    r[F_I] = 1'b1;
    return r;
  endfunction

  function automatic logic [PC_W-1:0] call_return(input logic [PC_W-1:0] pc);
    return pc + PC_W'(2);
  endfunction

  function automatic logic [PC_W-1:0] sub_return(input logic [DATA_W-1:0] hi,
                                                 input logic [DATA_W-1:0] lo);
    return {hi, lo} + PC_W'(1);
  endfunction

  function automatic logic [STEP_W-1:0] step_total(input sop_e op);
    case (op)
      OP_CALL, OP_RET: return STEP_W'(2);
      OP_BREAK:        return STEP_W'(5);
      OP_IRET:         return STEP_W'(3);
      default:         return STEP_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/stackseq_decode.sv
`timescale 1ns/1ps
module stackseq_decode
  import stackseq_pkg::*;
(
  input  sop_e              op,
  input  logic [STEP_W-1:0] step,
  output acc_e              acc,
  output wsel_e             wsel,
  output logic              vec_hi,
  output logic              last
);
  always_comb begin
    acc    = ACC_NONE;
    wsel   = WD_ACC;
    vec_hi = 1'b0;
    case (op)
      OP_PUSH_A: begin acc = ACC_PUSH; wsel = WD_ACC;  end
      OP_PUSH_P: begin acc = ACC_PUSH; wsel = WD_STAT; end
      OP_PULL_A, OP_PULL_P, OP_RET, OP_IRET: acc = ACC_PULL;
      OP_CALL: begin
        acc  = ACC_PUSH;
        wsel = (step == '0) ? WD_RETH : WD_RETL;
      end
      OP_BREAK: begin
        case (step)
          STEP_W'(0): begin acc = ACC_PUSH; wsel = WD_RETH; end
          STEP_W'(1): begin acc = ACC_PUSH; wsel = WD_RETL; end
          STEP_W'(2): begin acc = ACC_PUSH; wsel = WD_STAT; end
          STEP_W'(3): acc = ACC_VEC;
          default:    begin acc = ACC_VEC; vec_hi = 1'b1; end
        endcase
      end
      default: acc = ACC_NONE;
    endcase
    last = (step == step_total(op) - STEP_W'(1));
  end
endmodule

// File: rtl/stackseq_sp.sv
`timescale 1ns/1ps
module stackseq_sp
  import stackseq_pkg::*;
#(
  parameter logic [DATA_W-1:0] SP_RESET = 8'hFD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc,
  input  logic              dec,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] sp_up
);
  assign sp_up = sp + DATA_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp <= SP_RESET;
    else if (inc) sp <= sp_up;
    else if (dec) sp <= sp - DATA_W'(1);
  end
endmodule

// File: rtl/stackseq.sv
`timescale 1ns/1ps
module stackseq
  import stackseq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_RESET   = 8'hFD,
  parameter logic [15:0] BRK_VECTOR = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  op,
  input  logic [15:0] pc_in,
  input  logic [15:0] target,
  input  logic [7:0]  a_in,
  input  logic [5:0]  flags_in,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pc_out,
  output logic        pc_load,
  output logic [7:0]  a_out,
  output logic        a_load,
  output logic [5:0]  flags_out,
  output logic        flags_load,
  output logic [7:0]  sp_out,
  output logic        busy,
  output logic        done
);
  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  sop_e              op_q;
  logic [PC_W-1:0]   ret_q, tgt_q;
  logic [DATA_W-1:0] acc_q, hold0_q, hold1_q;
  logic [FLAG_W-1:0] flg_q;

  acc_e  acc;
  wsel_e wsel;
  logic  vec_hi, last;
  logic [DATA_W-1:0] sp_q, sp_up;

  // named events for the checker
  logic push_fire, pull_fire, vec_fire, rd_fire, stat_push;

  stackseq_decode dec_i (
    .op(op_q), .step(step_q), .acc(acc), .wsel(wsel), .vec_hi(vec_hi), .last(last)
  );

  assign push_fire = busy_q && (acc == ACC_PUSH);
  assign pull_fire = busy_q && (acc == ACC_PULL);
  assign vec_fire  = busy_q && (acc == ACC_VEC);
  assign rd_fire   = pull_fire || vec_fire;
  assign stat_push = push_fire && (wsel == WD_STAT);

  stackseq_sp #(.SP_RESET(SP_RESET)) sp_i (
    .clk(clk), .rst_n(rst_n), .inc(pull_fire), .dec(push_fire), .sp(sp_q), .sp_up(sp_up)
  );

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    if (push_fire) begin
      mem_addr = {STACK_PAGE, sp_q};
      case (wsel)
        WD_ACC:  mem_wdata = acc_q;
        WD_STAT: mem_wdata = pack_status(flg_q);
        WD_RETH: mem_wdata = ret_q[PC_W-1:DATA_W];
        default: mem_wdata = ret_q[DATA_W-1:0];
      endcase
    end else if (pull_fire) begin
      mem_addr = {STACK_PAGE, sp_up};
    end else if (vec_fire) begin
      mem_addr = BRK_VECTOR + {15'd0, vec_hi};
    end
  end

  assign mem_we = push_fire;
  assign mem_re = rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      step_q     <= '0;
      op_q       <= OP_PUSH_A;
      ret_q      <= '0;
      tgt_q      <= '0;
      acc_q      <= '0;
      flg_q      <= '0;
      hold0_q    <= '0;
      hold1_q    <= '0;
      pc_out     <= '0;
      a_out      <= '0;
      flags_out  <= '0;
      pc_load    <= 1'b0;
      a_load     <= 1'b0;
      flags_load <= 1'b0;
      done       <= 1'b0;
    end else begin
      done       <= 1'b0;
      pc_load    <= 1'b0;
      a_load     <= 1'b0;
      flags_load <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          step_q <= '0;
          op_q   <= sop_e'(op);
          ret_q  <= call_return(pc_in);
          tgt_q  <= target;
          acc_q  <= a_in;
          flg_q  <= flags_in;
        end
      end else begin
        if (rd_fire) begin
          hold0_q <= mem_rdata;
          hold1_q <= hold0_q;
        end
        if (last) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          case (op_q)
            OP_PULL_A: begin
              a_out      <= mem_rdata;
              a_load     <= 1'b1;
              flags_out  <= nz_update(flg_q, mem_rdata);
              flags_load <= 1'b1;
            end
            OP_PULL_P: begin
              flags_out  <= unpack_status(mem_rdata);
              flags_load <= 1'b1;
            end
            OP_CALL: begin
              pc_out  <= tgt_q;
              pc_load <= 1'b1;
            end
            OP_RET: begin
              pc_out  <= sub_return(mem_rdata, hold0_q);
              pc_load <= 1'b1;
            end
            OP_BREAK: begin
              pc_out     <= {mem_rdata, hold0_q};
              pc_load    <= 1'b1;
              flags_out  <= trap_flags(flg_q);
              flags_load <= 1'b1;
            end
            OP_IRET: begin
              pc_out     <= {mem_rdata, hold0_q};
              pc_load    <= 1'b1;
              flags_out  <= unpack_status(hold1_q);
              flags_load <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assign sp_out = sp_q;
  assign busy   = busy_q;
endmodule

// File: rtl/stackseq_chk.sv
`timescale 1ns/1ps
module stackseq_chk
  import stackseq_pkg::*;
#(
  parameter logic [7:0] PAGE = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        push_fire,
  input logic        pull_fire,
  input logic        vec_fire,
  input logic        stat_push,
  input logic [7:0]  sp,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata,
  input logic        done,
  input logic        pc_load,
  input logic        a_load,
  input logic        flags_load,
  input logic [5:0]  flags_out,
  input sop_e        op_q
);
  assert_push_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> sp == 8'($past(sp) - 8'd1));

  assert_push_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == PAGE);

  assert_pull_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pull_fire |=> sp == 8'($past(sp) + 8'd1));

  assert_pull_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && !vec_fire) |-> mem_addr[15:8] == PAGE);

  assert_stat_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_push |-> mem_wdata[5:4] == 2'b11);

  assert_push_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_PUSH_A || op_q == OP_PUSH_P)) |-> !(pc_load || a_load || flags_load));

  assert_trap_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_BREAK) |-> (!flags_out[F_D] && flags_out[F_I]));

  assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load || a_load || flags_load) |-> done);
endmodule

bind stackseq stackseq_chk #(.PAGE(STACK_PAGE)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_fire(push_fire), .pull_fire(pull_fire),
  .vec_fire(vec_fire), .stat_push(stat_push), .sp(sp_q), .mem_we(mem_we),
  .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
  .pc_load(pc_load), .a_load(a_load), .flags_load(flags_load),
  .flags_out(flags_out), .op_q(op_q)
);

// File: tb/stackseq_tb_top.sv
`timescale 1ns/1ps
module stackseq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] pc_in = '0, target = '0;
  logic [7:0]  a_in = '0;
  logic [5:0]  flags_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] pc_out;
  logic        pc_load, a_load, flags_load, busy, done;
  logic [7:0]  a_out, sp_out;
  logic [5:0]  flags_out;

  always #4 clk = ~clk;

  stackseq dut_i (.*);

  // memory model: stack page plus the two vector bytes
  logic [7:0]  stk [256];
  logic [7:0]  vec_lo = 8'h00, vec_hi = 8'hC0;
  logic        pre_en = 1'b0;
  logic [7:0]  pre_addr = '0, pre_data = '0;
  logic [15:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  logic [15:0] rlog_a [64];
  int wcount = 0, rcount = 0;

  assign mem_rdata = (mem_addr == 16'hFFFE) ? vec_lo :
                     (mem_addr == 16'hFFFF) ? vec_hi : stk[mem_addr[7:0]];

  always @(posedge clk) begin
    if (pre_en) stk[pre_addr] <= pre_data;
    if (mem_we) begin
      stk[mem_addr[7:0]] <= mem_wdata;
      wlog_a[wcount] <= mem_addr;
      wlog_d[wcount] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (mem_re) begin
      rlog_a[rcount] <= mem_addr;
      rcount <= rcount + 1;
    end
  end

  int nchecks = 0, nerr = 0;
  logic [7:0] exp_sp = 8'hFD;
  int wbase, rbase;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchecks++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // status byte per R3, written as a sum of weights
  function automatic logic [7:0] status_of(input logic [5:0] f);
    int s;
    s = 48 + (f[5] ? 128 : 0) + (f[4] ? 64 : 0) + (f[3] ? 8 : 0)
           + (f[2] ? 4 : 0) + (f[1] ? 2 : 0) + (f[0] ? 1 : 0);
    return 8'(s);
  endfunction

  function automatic logic [5:0] flags_of(input logic [7:0] b);
    return {b[7], b[6], b[3], b[2], b[1], b[0]};
  endfunction

  task automatic poke(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = addr; pre_data = data;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [15:0] pc, input logic [15:0] tg,
                        input logic [7:0] a, input logic [5:0] f, input int steps,
                        input string tag);
    int cyc;
    @(negedge clk);
    op = o; pc_in = pc; target = tg; a_in = a; flags_in = f; start = 1'b1;
    wbase = wcount; rbase = rcount;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    chk({tag, " R11 latency"}, cyc, steps + 1);
  endtask

  task automatic t_reset();
    chk("R12 sp after reset", sp_out, 8'hFD);
    chk("R12 busy after reset", busy, 0);
    chk("R12 done after reset", done, 0);
    chk("R12 no access after reset", {mem_we, mem_re, pc_load, a_load, flags_load}, 0);
  endtask

  task automatic t_push_a(input logic [7:0] v);
    run_op(3'd0, 16'h0, 16'h0, v, 6'b010101, 1, "R13 push A");
    chk("R1 push A count", wcount - wbase, 1);
    chk("R1 push A addr", wlog_a[wbase], {8'h01, exp_sp});
    chk("R1 push A data", wlog_d[wbase], v);
    exp_sp = exp_sp - 8'd1;
    chk("R1 sp after push", sp_out, exp_sp);
    chk("R6 push A strobes", {pc_load, a_load, flags_load}, 0);
  endtask

  task automatic t_push_p(input logic [5:0] f);
    run_op(3'd1, 16'h0, 16'h0, 8'h00, f, 1, "R13 push P");
    chk("R3 status addr", wlog_a[wbase], {8'h01, exp_sp});
    chk("R3 status byte", wlog_d[wbase], status_of(f));
    exp_sp = exp_sp - 8'd1;
    chk("R6 push P strobes", {pc_load, a_load, flags_load}, 0);
  endtask

  task automatic t_pull_a(input logic [7:0] v, input logic [5:0] f);
    poke(exp_sp + 8'd1, v);
    run_op(3'd2, 16'h0, 16'h0, 8'h33, f, 1, "R13 pull A");
    chk("R2 pull addr", rlog_a[rbase], {8'h01, exp_sp + 8'd1});
    exp_sp = exp_sp + 8'd1;
    chk("R2 sp after pull", sp_out, exp_sp);
    chk("R5 a_out", a_out, v);
    chk("R5 a_load", a_load, 1);
    chk("R5 flags", {flags_load, flags_out}, {1'b1, v[7], f[4:2], (v == 8'h00), f[0]});
  endtask

  task automatic t_pull_p(input logic [7:0] v, input logic [5:0] f);
    poke(exp_sp + 8'd1, v);
    run_op(3'd3, 16'h0, 16'h0, 8'h00, f, 1, "R13 pull P");
    exp_sp = exp_sp + 8'd1;
    chk("R4 flags", {flags_load, flags_out}, {1'b1, flags_of(v)});
    chk("R4 no acc/pc", {a_load, pc_load}, 0);
  endtask

  task automatic t_call(input logic [15:0] pc, input logic [15:0] tg);
    logic [15:0] r;
    r = pc + 16'd2;
    run_op(3'd4, pc, tg, 8'h00, 6'b0, 2, "R13 call");
    chk("R7 count", wcount - wbase, 2);
    chk("R7 hi addr", wlog_a[wbase], {8'h01, exp_sp});
    chk("R7 hi data", wlog_d[wbase], r[15:8]);
    chk("R7 lo addr", wlog_a[wbase + 1], {8'h01, exp_sp - 8'd1});
    chk("R7 lo data", wlog_d[wbase + 1], r[7:0]);
    exp_sp = exp_sp - 8'd2;
    chk("R7 sp", sp_out, exp_sp);
    chk("R7 pc", {pc_load, pc_out}, {1'b1, tg});
  endtask

  task automatic t_ret(input logic [7:0] lo, input logic [7:0] hi);
    poke(exp_sp + 8'd1, lo);
    poke(exp_sp + 8'd2, hi);
    run_op(3'd5, 16'h0, 16'h0, 8'h00, 6'b0, 2, "R13 return");
    chk("R8 first read", rlog_a[rbase], {8'h01, exp_sp + 8'd1});
    chk("R8 second read", rlog_a[rbase + 1], {8'h01, exp_sp + 8'd2});
    exp_sp = exp_sp + 8'd2;
    chk("R8 pc", {pc_load, pc_out}, {1'b1, 16'({hi, lo} + 17'd1)});
    chk("R8 no flags", flags_load, 0);
  endtask

  task automatic t_break(input logic [15:0] pc, input logic [5:0] f);
    logic [15:0] r;
    r = pc + 16'd2;
    run_op(3'd6, pc, 16'h0, 8'h00, f, 5, "R13 break");
    chk("R9 writes", wcount - wbase, 3);
    chk("R9 pch", {wlog_a[wbase], wlog_d[wbase]}, {8'h01, exp_sp, r[15:8]});
    chk("R9 pcl", {wlog_a[wbase + 1], wlog_d[wbase + 1]}, {8'h01, exp_sp - 8'd1, r[7:0]});
    chk("R9 status", {wlog_a[wbase + 2], wlog_d[wbase + 2]},
        {8'h01, exp_sp - 8'd2, status_of(f)});
    chk("R9 vector reads", {rlog_a[rbase], rlog_a[rbase + 1]}, {16'hFFFE, 16'hFFFF});
    exp_sp = exp_sp - 8'd3;
    chk("R9 sp", sp_out, exp_sp);
    chk("R9 pc", {pc_load, pc_out}, {1'b1, vec_hi, vec_lo});
    chk("R9 flags", {flags_load, flags_out}, {1'b1, f[5:4], 1'b0, 1'b1, f[1:0]});
  endtask

  task automatic t_iret(input logic [7:0] st, input logic [7:0] lo, input logic [7:0] hi);
    poke(exp_sp + 8'd1, st);
    poke(exp_sp + 8'd2, lo);
    poke(exp_sp + 8'd3, hi);
    run_op(3'd7, 16'h0, 16'h0, 8'h00, 6'b0, 3, "R13 iret");
    exp_sp = exp_sp + 8'd3;
    chk("R10 sp", sp_out, exp_sp);
    chk("R10 pc no increment", {pc_load, pc_out}, {1'b1, hi, lo});
    chk("R10 flags", {flags_load, flags_out}, {1'b1, flags_of(st)});
  endtask

  task automatic t_start_while_busy();
    int cyc;
    @(negedge clk);
    op = 3'd4; pc_in = 16'h2000; target = 16'h3000; start = 1'b1;
    wbase = wcount;
    @(negedge clk);
    op = 3'd0; a_in = 8'hEE;
    chk("R11 busy during op", busy, 1);
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    repeat (3) @(negedge clk);
    chk("R11 start ignored, writes", wcount - wbase, 2);
    exp_sp = exp_sp - 8'd2;
    chk("R11 start ignored, sp", sp_out, exp_sp);
    chk("R11 pc held", pc_out, 16'h3000);
    chk("R11 idle after", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_a(8'h5A);
    t_push_p(6'b101010);
    t_push_p(6'b000000);
    t_push_p(6'b111111);
    t_pull_a(8'h00, 6'b100000);
    t_pull_a(8'h80, 6'b011101);
    t_pull_p(8'hCF, 6'b000000);
    t_pull_p(8'h30, 6'b111111);
    t_call(16'h1234, 16'h8000);
    t_call(16'hFFFF, 16'h0400);
    t_ret(8'hFF, 8'h12);
    t_ret(8'hFF, 8'hFF);
    t_break(16'h40FE, 6'b001001);
    t_iret(8'hC3, 8'hFF, 8'h12);
    t_iret(8'h3C, 8'h34, 8'h56);
    t_start_while_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nerr++;
      $display("FAIL R11 watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule